// File: doc/BRIEF.md
# Maskable Interrupt Flag and Enable Controller with Debug Gating

This block collects interrupt requests from two kinds of origin and presents one request line to a processor core, together with the index of the source that should be taken first. Peripheral logic raises one-cycle request pulses that set pending flags directly. External interrupt pins, which are active low, are captured on the falling clock edge, moved into the rising-edge domain and accepted only after a strict high-then-low sample pattern. Pending flags, enable masks and a second mask used during debug are each held as two 16-bit banks, and software reaches all six registers through a small read/write port.

The core signals with a mode input whether it is running or halted for real-time debug. While running, a pending flag whose enable bit is set qualifies. While halted, the debug mask must also allow the source; such sources are the time-critical ones. The debug mask is never cleared by either reset, so software loads it once before entering debug. The core pulses an acknowledge input to retire the flag of the source that currently wins.

Top module: `irq_flag_ctl`

## Requirements
- R1: A hardware reset (`rst` high at a rising edge) clears every pending flag and enable bit, after which `irq_req` is 0. Register addresses: 0 = pending bank 0, 1 = pending bank 1, 2 = enable bank 0, 3 = enable bank 1, 4 = debug mask bank 0, 5 = debug mask bank 1; addresses 6 and 7 read as zero. Source index n is bit n of bank 0 for n below 16 and bit n-16 of bank 1 otherwise.
- R2: Reserved bits always read as zero and keep no written value: bits 0, 1 and 8 of bank 0 and bits 11 to 15 of bank 1, in all three register kinds.
- R3: Writing a 1 to a pending bit clears it and writing a 0 leaves it; when a hardware set reaches the same bit in the same cycle, the flag stays set.
- R4: With `dbg_halt` low, a source qualifies when its pending flag and enable bit are both 1; the debug mask has no effect.
- R5: With `dbg_halt` high, a source qualifies only if its pending flag, enable bit and debug mask bit are all 1; `irq_req` and `irq_id` follow `dbg_halt` in the same cycle.
- R6: The debug mask registers change only when written; neither `rst` nor `sw_rst` alters them.
- R7: A software reset (`sw_rst` high at a rising edge) clears pending flags and enables, exactly as a hardware reset does.
- R8: An external pin is sampled at each falling clock edge; a flag is set only when four consecutive samples read 1, 0, 0, 0, so a low pulse of two samples is ignored and one of three or more samples sets the flag once. Pin 0 to pin 5 map to source indices 2, 16, 3, 11, 19 and 23.
- R9: When several sources qualify, `irq_id` is the lowest qualifying source index, so bank 0 wins over bank 1.
- R10: An `ack` pulse while `irq_req` is 1 clears the pending flag of the source shown on `irq_id` at that edge.
- R11: A `periph_req` bit sets its pending flag at the next rising edge, except at reserved positions and at the six external pin positions, where it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pins are sampled on its falling edge |
| rst | input | 1 | Synchronous active-high hardware reset |
| sw_rst | input | 1 | Synchronous active-high software reset |
| dbg_halt | input | 1 | 1 when the core is halted for real-time debug |
| ext_irq_n | input | 6 | Active-low external interrupt pins |
| periph_req | input | 32 | One-cycle set pulses, one per source index |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the addressed register |
| ack | input | 1 | Acknowledge of the current winner |
| irq_req | output | 1 | At least one source qualifies |
| irq_id | output | 5 | Index of the winning source |

## Verification
The bench chases the pin pattern boundary: a two-sample low pulse must leave the flag clear, while a three-sample pulse must set it, so a detector that triggers on any falling edge or needs one more low sample shows up as a wrong pending read. It forces a peripheral set and a write-one-clear onto the same bit in one cycle, which exposes a design where the clear wins. It applies both resets after loading the debug masks and reads them back, catching a mask wired to a reset, and toggles the halt input with flags pending to catch a gate that ignores the mask or applies it while running. Acknowledge with flags in both banks checks that the retired flag is the winner and that bank 0 outranks bank 1.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int BANK_W   = 16;
    localparam int NBANK    = 2;
    localparam int NSRC     = BANK_W * NBANK;
    localparam int ID_W     = $clog2(NSRC);
    localparam int BSEL_W   = (NBANK > 1) ? $clog2(NBANK) : 1;
    localparam int ADDR_W   = 3;
    localparam int NEXT     = 6;
    localparam int HIST_LEN = 4;

    typedef logic [NSRC-1:0] src_vec_t;

    // implemented source positions over both banks (bank 1 in the upper half)
    localparam src_vec_t SRC_VALID = 32'h07FF_FEFC;

    // oldest sample in the top bit: one high, then three lows
    localparam logic [HIST_LEN-1:0] DET_PATTERN = 4'b1000;

    typedef enum logic [1:0] {
        KIND_PEND = 2'd0,
        KIND_EN   = 2'd1,
        KIND_DBG  = 2'd2,
        KIND_NONE = 2'd3
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e          kind;
        logic [BSEL_W-1:0]  bank;
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        int       k;
        k      = int'(a) / NBANK;
        s.bank = BSEL_W'(int'(a) % NBANK);
        case (k)
            0:       s.kind = KIND_PEND;
            1:       s.kind = KIND_EN;
            2:       s.kind = KIND_DBG;
            default: s.kind = KIND_NONE;
        endcase
        return s;
    endfunction

    function automatic int ext_pin_pos(input int pin);
        case (pin)
            0:       return 2;
            1:       return 16;
            2:       return 3;
            3:       return 11;
            4:       return 19;
            5:       return 23;
            default: return 0;
        endcase
    endfunction

    function automatic src_vec_t ext_mask();
        src_vec_t m;
        m = '0;
        for (int p = 0; p < NEXT; p++) m[ext_pin_pos(p)] = 1'b1;
        return m;
    endfunction

    function automatic src_vec_t periph_mask();
        return SRC_VALID & ~ext_mask();
    endfunction

    function automatic src_vec_t bank_bits(input logic [BSEL_W-1:0] b);
        src_vec_t m;
        m = '0;
        for (int i = 0; i < BANK_W; i++) m[int'(b) * BANK_W + i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync
    import irq_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic det
);

    logic                s_fall;
    logic [HIST_LEN-1:0] hist;

    // capture on the falling edge, then carry into the rising-edge domain
    always_ff @(negedge clk) begin
        s_fall <= pin_n;
    end

    always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else     hist <= {hist[HIST_LEN-2:0], s_fall};
    end

    assign det = (hist == DET_PATTERN);

    a_r8_single_detect: assert property (@(posedge clk) disable iff (rst)
        det |=> !det);

endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
    import irq_ctl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sw_rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BANK_W-1:0]   wdata,
    input  src_vec_t            hw_set,
    input  src_vec_t            ack_clr,
    output src_vec_t            pend,
    output src_vec_t            enab,
    output src_vec_t            dbg,
    output logic [BANK_W-1:0]   rdata
);

    reg_sel_t sel;
    src_vec_t wvec, sel_bits, pend_wclr, en_upd, dbg_upd, en_next, dbg_next;

    assign sel      = decode_addr(addr);
    assign wvec     = {NBANK{wdata}};
    assign sel_bits = bank_bits(sel.bank);

    always_comb begin
        pend_wclr = '0;
        en_upd    = '0;
        dbg_upd   = '0;
        if (wr_en) begin
            case (sel.kind)
                KIND_PEND: pend_wclr = wvec & sel_bits;
                KIND_EN:   en_upd    = sel_bits;
                KIND_DBG:  dbg_upd   = sel_bits;
                default:   ;
            endcase
        end
        en_next  = (enab & ~en_upd)  | (wvec & en_upd  & SRC_VALID);
        dbg_next = (dbg  & ~dbg_upd) | (wvec & dbg_upd & SRC_VALID);
    end

    // flags and enables follow both resets; sets beat clears
    always_ff @(posedge clk) begin
        if (rst || sw_rst) begin
            pend <= '0;
            enab <= '0;
        end else begin
            pend <= ((pend & ~(pend_wclr | ack_clr)) | hw_set) & SRC_VALID;
            enab <= en_next;
        end
    end

    // debug mask: no reset of either kind
    always_ff @(posedge clk) begin
        dbg <= dbg_next;
    end

    always_comb begin
        case (sel.kind)
            KIND_PEND: rdata = pend[int'(sel.bank) * BANK_W +: BANK_W];
            KIND_EN:   rdata = enab[int'(sel.bank) * BANK_W +: BANK_W];
            KIND_DBG:  rdata = dbg [int'(sel.bank) * BANK_W +: BANK_W];
            default:   rdata = '0;
        endcase
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        $fell(rst) |-> (pend == '0 && enab == '0));

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (sel.kind != KIND_NONE) |->
            ((rdata & ~SRC_VALID[int'(sel.bank) * BANK_W +: BANK_W]) == '0));

    a_r3_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        ((pend_wclr & ~hw_set) != '0) |=> ((pend & $past(pend_wclr & ~hw_set)) == '0));

    a_r3_set_wins: assert property (@(posedge clk) disable iff (rst)
        ((hw_set & SRC_VALID) != '0 && !sw_rst) |=>
            ((pend & $past(hw_set & SRC_VALID)) == $past(hw_set & SRC_VALID)));

    a_r6_dbg_kept: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sel.kind == KIND_DBG) |=> $stable(dbg));

    a_r7_soft_reset: assert property (@(posedge clk) disable iff (rst)
        sw_rst |=> (pend == '0 && enab == '0));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             dbg_halt,
    input  src_vec_t         pend,
    input  src_vec_t         enab,
    input  src_vec_t         dbg,
    output logic             irq_req,
    output logic [ID_W-1:0]  irq_id
);

    src_vec_t gate, qual;

    assign gate    = dbg_halt ? dbg : '1;
    assign qual    = pend & enab & gate;
    assign irq_req = |qual;

    // lowest index wins: scan from the top so the last hit is the lowest
    always_comb begin
        irq_id = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (qual[i]) irq_id = ID_W'(i);
        end
    end

    a_r4_flag_and_enable: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (pend[irq_id] && enab[irq_id]));

    a_r5_halt_gate: assert property (@(posedge clk) disable iff (rst)
        (irq_req && dbg_halt) |-> dbg[irq_id]);

    a_r9_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> ((pend & enab & gate & ((src_vec_t'(1) << irq_id) - src_vec_t'(1))) == '0));

endmodule

// File: rtl/irq_flag_ctl.sv
module irq_flag_ctl
    import irq_ctl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sw_rst,
    input  logic                dbg_halt,
    input  logic [NEXT-1:0]     ext_irq_n,
    input  logic [NSRC-1:0]     periph_req,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BANK_W-1:0]   wdata,
    output logic [BANK_W-1:0]   rdata,
    input  logic                ack,
    output logic                irq_req,
    output logic [ID_W-1:0]     irq_id
);

    logic [NEXT-1:0] ext_det;
    src_vec_t        ext_set, hw_set, ack_clr, pend, enab, dbg;

    for (genvar p = 0; p < NEXT; p++) begin : g_pin
        irq_pin_sync u_sync (
            .clk   (clk),
            .rst   (rst),
            .pin_n (ext_irq_n[p]),
            .det   (ext_det[p])
        );
    end

    always_comb begin
        ext_set = '0;
        for (int p = 0; p < NEXT; p++) begin
            if (ext_det[p]) ext_set[ext_pin_pos(p)] = 1'b1;
        end
    end

    assign hw_set = ext_set | (periph_req & periph_mask());

    always_comb begin
        ack_clr = '0;
        if (ack && irq_req) ack_clr[irq_id] = 1'b1;
    end

    irq_reg_file u_regs (
        .clk     (clk),
        .rst     (rst),
        .sw_rst  (sw_rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .hw_set  (hw_set),
        .ack_clr (ack_clr),
        .pend    (pend),
        .enab    (enab),
        .dbg     (dbg),
        .rdata   (rdata)
    );

    irq_arbiter u_arb (
        .clk      (clk),
        .rst      (rst),
        .dbg_halt (dbg_halt),
        .pend     (pend),
        .enab     (enab),
        .dbg      (dbg),
        .irq_req  (irq_req),
        .irq_id   (irq_id)
    );

    a_r10_ack_retires: assert property (@(posedge clk) disable iff (rst)
        (ack && irq_req && !hw_set[irq_id]) |=> !pend[$past(irq_id)]);

    a_r11_periph_sets: assert property (@(posedge clk) disable iff (rst)
        (((periph_req & periph_mask()) != '0) && !sw_rst) |=>
            ((pend & $past(periph_req & periph_mask())) == $past(periph_req & periph_mask())));

endmodule

// File: tb/sim_irq_flag_ctl.sv
module sim_irq_flag_ctl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_rst = 1'b0;
    logic        dbg_halt = 1'b0;
    logic [5:0]  ext_n = 6'h3F;
    logic [31:0] preq = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        ack = 1'b0;
    logic [15:0] rdata;
    logic        irq_req;
    logic [4:0]  irq_id;

    int    n_chk = 0;
    int    n_fail = 0;
    string tag = "R1";
    bit    done = 1'b0;
    bit    dbg_ok = 1'b0;

    localparam bit [31:0] VAL = 32'h07FF_FEFC;
    int pinpos [6] = '{2, 16, 3, 11, 19, 23};

    bit [31:0] mf = '0, me = '0, md = '0;
    bit [3:0]  mh [6];
    bit        mr;
    int        mid;

    always #2 clk = ~clk;   // 4 ns period

    irq_flag_ctl u0 (
        .clk(clk), .rst(rst), .sw_rst(sw_rst), .dbg_halt(dbg_halt),
        .ext_irq_n(ext_n), .periph_req(preq), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ack(ack), .irq_req(irq_req), .irq_id(irq_id)
    );

    function automatic bit [31:0] pmask();
        bit [31:0] m;
        m = VAL;
        for (int p = 0; p < 6; p++) m[pinpos[p]] = 1'b0;
        return m;
    endfunction

    function automatic bit [15:0] model_rd(input logic [2:0] a);
        case (a)
            3'd0: return mf[15:0];
            3'd1: return mf[31:16];
            3'd2: return me[15:0];
            3'd3: return me[31:16];
            3'd4: return md[15:0];
            3'd5: return md[31:16];
            default: return 16'h0;
        endcase
    endfunction

    task automatic check(input bit ok, input string t, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    // reference model: compare then advance, once per cycle before the next edge
    always @(posedge clk) begin : mdl
        bit [31:0] nset, nclr;
        #3;
        mr = 1'b0; mid = 0;
        for (int i = 0; i < 32; i++) begin
            if (!mr && mf[i] && me[i] && (!dbg_halt || md[i])) begin
                mr = 1'b1; mid = i;
            end
        end
        if (!rst) begin
            check(irq_req == mr, tag, "irq_req", int'(irq_req), int'(mr));
            if (mr) check(int'(irq_id) == mid, tag, "irq_id", int'(irq_id), mid);
            if (addr < 3'd4 || dbg_ok)
                check(rdata == model_rd(addr), tag, "rdata", int'(rdata), int'(model_rd(addr)));
        end
        if (rst) begin
            mf = '0; me = '0;
            for (int p = 0; p < 6; p++) mh[p] = 4'h0;
        end else begin
            nset = preq & pmask();
            for (int p = 0; p < 6; p++) if (mh[p] == 4'b1000) nset[pinpos[p]] = 1'b1;
            nclr = '0;
            if (ack && mr) nclr[mid] = 1'b1;
            if (wr_en && addr == 3'd0) nclr[15:0]  = nclr[15:0]  | wdata;
            if (wr_en && addr == 3'd1) nclr[31:16] = nclr[31:16] | wdata;
            if (sw_rst) begin
                mf = '0; me = '0;
            end else begin
                mf = ((mf & ~nclr) | nset) & VAL;
                if (wr_en && addr == 3'd2) me[15:0]  = wdata & VAL[15:0];
                if (wr_en && addr == 3'd3) me[31:16] = wdata & VAL[31:16];
            end
            for (int p = 0; p < 6; p++) mh[p] = {mh[p][2:0], ext_n[p]};
        end
        if (wr_en && addr == 3'd4) md[15:0]  = wdata & VAL[15:0];
        if (wr_en && addr == 3'd5) md[31:16] = wdata & VAL[31:16];
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        step();
        addr = a; wdata = d; wr_en = 1'b1;
        step();
        wr_en = 1'b0;
    endtask

    task automatic pulse_req(input logic [31:0] v);
        step();
        preq = v;
        step();
        preq = '0;
    endtask

    task automatic pulse_ack();
        step();
        ack = 1'b1;
        step();
        ack = 1'b0;
    endtask

    task automatic pin_low(input int p, input int n);
        step();
        ext_n[p] = 1'b0;
        repeat (n) step();
        ext_n[p] = 1'b1;
    endtask

    task automatic rd_expect(input logic [2:0] a, input logic [15:0] e, input string t);
        step();
        addr = a;
        #1;
        check(rdata == e, t, "read", int'(rdata), int'(e));
    endtask

    task automatic irq_expect(input bit r, input int id, input string t);
        step();
        #1;
        check(irq_req == r, t, "irq_req", int'(irq_req), int'(r));
        if (r) check(int'(irq_id) == id, t, "irq_id", int'(irq_id), id);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (2) step();
        wr(3'd4, 16'h0010);          // debug masks loaded during reset
        wr(3'd5, 16'h0000);
        dbg_ok = 1'b1;
        step();
        rst = 1'b0;

        tag = "R1";
        rd_expect(3'd0, 16'h0, "R1");
        rd_expect(3'd1, 16'h0, "R1");
        rd_expect(3'd2, 16'h0, "R1");
        rd_expect(3'd3, 16'h0, "R1");
        rd_expect(3'd6, 16'h0, "R1");
        irq_expect(1'b0, 0, "R1");

        tag = "R2";
        wr(3'd2, 16'hFFFF);
        wr(3'd3, 16'hFFFF);
        rd_expect(3'd2, 16'hFEFC, "R2");
        rd_expect(3'd3, 16'h07FF, "R2");

        tag = "R11";
        pulse_req(32'h0000_0114);    // bit 4 valid, bit 2 pin slot, bit 8 reserved
        rd_expect(3'd0, 16'h0010, "R11");
        irq_expect(1'b1, 4, "R4");

        tag = "R9";
        pulse_req(32'h0002_0000);    // source 17
        irq_expect(1'b1, 4, "R9");
        tag = "R10";
        pulse_ack();
        irq_expect(1'b1, 17, "R10");
        rd_expect(3'd0, 16'h0, "R10");

        tag = "R5";
        dbg_halt = 1'b1;
        irq_expect(1'b0, 0, "R5");
        wr(3'd5, 16'h0002);
        irq_expect(1'b1, 17, "R5");
        wr(3'd5, 16'h0000);
        irq_expect(1'b0, 0, "R5");
        tag = "R4";
        dbg_halt = 1'b0;
        irq_expect(1'b1, 17, "R4");
        wr(3'd5, 16'h0002);

        tag = "R3";
        wr(3'd1, 16'h0002);
        rd_expect(3'd1, 16'h0, "R3");
        step();
        preq = 32'h0000_0020; addr = 3'd0; wdata = 16'h0020; wr_en = 1'b1;
        step();
        preq = '0; wr_en = 1'b0;
        rd_expect(3'd0, 16'h0020, "R3");

        tag = "R7";
        step();
        sw_rst = 1'b1;
        step();
        sw_rst = 1'b0;
        rd_expect(3'd0, 16'h0, "R7");
        rd_expect(3'd2, 16'h0, "R7");
        rd_expect(3'd5, 16'h0002, "R6");

        tag = "R6";
        step();
        rst = 1'b1;
        repeat (2) step();
        rst = 1'b0;
        rd_expect(3'd4, 16'h0010, "R6");
        rd_expect(3'd5, 16'h0002, "R6");
        rd_expect(3'd3, 16'h0, "R1");

        tag = "R8";
        wr(3'd2, 16'hFFFF);
        wr(3'd3, 16'hFFFF);
        repeat (4) step();
        pin_low(0, 2);
        repeat (8) step();
        rd_expect(3'd0, 16'h0, "R8");
        pin_low(0, 3);
        repeat (8) step();
        rd_expect(3'd0, 16'h0004, "R8");
        pin_low(1, 3);
        repeat (8) step();
        rd_expect(3'd1, 16'h0001, "R8");

        tag = "R9";
        irq_expect(1'b1, 2, "R9");
        pulse_ack();
        irq_expect(1'b1, 16, "R9");
        pin_low(5, 6);
        repeat (8) step();
        rd_expect(3'd1, 16'h0081, "R8");
        pulse_ack();
        irq_expect(1'b1, 23, "R10");
        pulse_ack();
        irq_expect(1'b0, 0, "R10");

        repeat (4) step();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule